// File: doc/BRIEF.md
# Eight-Digit Character Display Write Port

This block is the host-facing register file of an eight-character dot-matrix display controller. A host drives an 8-bit data bus, a 4-bit address and three active-low strobes: chip enable, write, and a flash-select line. The strobes are brought into the system clock domain, and each bus cycle results in exactly one write. The write goes to one of three stores. The first is the character memory, which holds a 7-bit code and a font-page bit per digit. The second is the per-digit flash bits. The third is a single 8-bit control word.

Bit 7 of the control word starts a clear cycle. For a parameterised number of system clocks, every character location is forced to the blank code 20h and every flash bit is forced to zero. During that window, a host character write is overwritten. Writing a control word with bit 7 low ends the window at once. Reset loads blanks, zeroes the flash bits and zeroes the control word. The stored contents are presented on flat output vectors for the scan logic.

Top module: `disp_regfile`

## Requirements
- R1: No store changes unless chip enable and write are low together. Write low with chip enable high changes nothing, and the same holds for chip enable low with write high.
- R2: With flash-select high and address bit 3 = 1, the full data byte is stored in the character location chosen by address bits 2..0. Bits 6..0 are the code and bit 7 is the font page. Digit n occupies char_o[8n+7:8n], and digit 0 is the leftmost.
- R3: With flash-select high and address bit 3 = 0, the data byte is stored in the control word, whatever address bits 2..0 hold.
- R4: With flash-select low, data bit 0 is written to flash_o[n] for the digit n given by address bits 2..0. Address bit 3 and data bits 7..1 have no effect.
- R5: While reset is low, every character location reads 20h, all flash bits read 0, the control word reads 00h and clr_busy_o reads 0.
- R6: A control write with bit 7 = 1 does all of the following:
  - It sets every character location to 20h and every flash bit to 0.
  - It keeps the written control value.
  - It holds clr_busy_o high for exactly CLR_CYCLES clocks.
- R7: While clr_busy_o is high, character writes and flash writes leave the locations at 20h and 0.
- R8: A control write with bit 7 = 0 during a clear cycle drops clr_busy_o immediately, and later character writes take effect.
- R9: A strobe held low for many clocks performs one write, which uses the data present when the write was first recognised.
- R10: Once the clear cycle has run out, character writes take effect even though control bit 7 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_fl_n | input | 1 | Flash-bit select, active low |
| bus_addr | input | AW+1 (4) | Bit AW selects character (1) or control (0); lower bits pick the digit |
| bus_data | input | 8 | Host write data |
| char_o | output | NDIG*8 (64) | Stored character bytes, digit n at [8n+7:8n] |
| flash_o | output | NDIG (8) | Per-digit flash bits |
| ctrl_o | output | 8 | Control word |
| clr_busy_o | output | 1 | High while a clear cycle is running |

## Verification
A wrong decode of the strobe combination or of the mode bit writes the wrong store. That error shows on char_o, flash_o or ctrl_o within three clocks of the strobe edge. A clear counter with an off-by-one error shows as a busy window of the wrong length, which the bench measures to the clock. Wrong priority between blanking and host writes shows as a non-blank character that is read while clr_busy_o is still high. A write detector that triggers on level rather than on edge shows as a stored byte that follows data changed in the middle of a strobe.

// File: rtl/disp_regfile.sv
module disp_regfile #(
  parameter int NDIG       = 8,
  parameter int CLR_CYCLES = 48,
  localparam int AW        = $clog2(NDIG),
  localparam int CW        = $clog2(CLR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_wr_n,
  input  logic              bus_fl_n,
  input  logic [AW:0]       bus_addr,
  input  logic [7:0]        bus_data,
  output logic [NDIG*8-1:0] char_o,
  output logic [NDIG-1:0]   flash_o,
  output logic [7:0]        ctrl_o,
  output logic              clr_busy_o
);
  localparam logic [7:0] BLANK = 8'h20;

  logic [2:0]    act_sh;
  logic [1:0]    fl_sh;
  logic [CW-1:0] clr_cnt;
  logic [7:0]    chr_q [NDIG];
  logic [NDIG-1:0] flash_q;
  logic [7:0]    ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sh <= '0;
      fl_sh  <= '1;
    end else begin
      act_sh <= {act_sh[1:0], ~bus_ce_n & ~bus_wr_n};
      fl_sh  <= {fl_sh[0], bus_fl_n};
    end
  end

  wire          wr_pulse  = act_sh[1] & ~act_sh[2];
  wire          we_flash  = wr_pulse & ~fl_sh[1];
  wire          we_char   = wr_pulse &  fl_sh[1] &  bus_addr[AW];
  wire          we_ctrl   = wr_pulse &  fl_sh[1] & ~bus_addr[AW];
  wire          clr_start = we_ctrl &  bus_data[7];
  wire          clr_stop  = we_ctrl & ~bus_data[7];
  wire [AW-1:0] dig       = bus_addr[AW-1:0];
  wire          busy      = (clr_cnt != '0);
  wire          blank_now = clr_start | (busy & ~clr_stop);

  always_ff @(posedge clk) begin
    if (!rst_n)              clr_cnt <= '0;
    else if (clr_start)      clr_cnt <= CW'(CLR_CYCLES);
    else if (clr_stop)       clr_cnt <= '0;
    else if (busy)           clr_cnt <= clr_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || blank_now) begin
      for (int i = 0; i < NDIG; i++) chr_q[i] <= BLANK;
      flash_q <= '0;
    end else begin
      if (we_char)  chr_q[dig]   <= bus_data;
      if (we_flash) flash_q[dig] <= bus_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= bus_data;
  end

  always_comb
    for (int i = 0; i < NDIG; i++) char_o[i*8 +: 8] = chr_q[i];

  assign flash_o    = flash_q;
  assign ctrl_o     = ctrl_q;
  assign clr_busy_o = busy;

  AST_ONE_TARGET:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({we_char, we_flash, we_ctrl})); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_pulse |=> !wr_pulse); // R9
  AST_BUSY_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr_busy_o |-> ctrl_q[7]); // R6
  AST_BUSY_FLASH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr_busy_o |-> flash_q == '0); // R7
  AST_BUSY_BLANK0: assert property (@(posedge clk) disable iff (!rst_n) clr_busy_o |-> chr_q[0] == BLANK); // R7
  AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) clr_cnt <= CW'(CLR_CYCLES)); // R6
  AST_STOP_DROPS:  assert property (@(posedge clk) disable iff (!rst_n) clr_stop |=> !clr_busy_o); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_pulse && !clr_busy_o |=> $stable(ctrl_q)); // R1
endmodule

// File: tb/disp_regfile_tb.sv
module disp_regfile_tb;
  localparam int NDIG = 8;
  localparam int CLR  = 48;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, wr_n = 1, fl_n = 1;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic [NDIG*8-1:0] char_o;
  logic [NDIG-1:0] flash_o;
  logic [7:0] ctrl_o;
  logic busy;

  always #2.5 clk = ~clk;

  disp_regfile #(.NDIG(NDIG), .CLR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_wr_n(wr_n), .bus_fl_n(fl_n),
    .bus_addr(addr), .bus_data(data), .char_o(char_o), .flash_o(flash_o),
    .ctrl_o(ctrl_o), .clr_busy_o(busy));

  typedef struct { string req; int kind; int idx; logic [7:0] exp; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0, busy_cycles = 0;
  logic [7:0] m_chr [NDIG];
  logic [NDIG-1:0] m_fl;
  logic [7:0] m_ctrl;

  function automatic logic [7:0] probe(int k, int i);
    case (k)
      0: return char_o[i*8 +: 8];
      1: return {7'b0, flash_o[i]};
      2: return ctrl_o;
      default: return {7'b0, busy};
    endcase
  endfunction

  always @(negedge clk) begin
    if (busy) busy_cycles++;
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      act = probe(it.kind, it.idx);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic push(string r, int k, int i, logic [7:0] e);
    item_t it;
    it.req = r; it.kind = k; it.idx = i; it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic push_all(string r, logic b);
    for (int i = 0; i < NDIG; i++) begin
      push(r, 0, i, m_chr[i]);
      push(r, 1, i, {7'b0, m_fl[i]});
    end
    push(r, 2, 0, m_ctrl);
    push(r, 3, 0, {7'b0, b});
    @(negedge clk);
  endtask

  task automatic bus_cycle(logic ce, logic wr, logic fl, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; fl_n = fl;
    @(negedge clk);
    ce_n = ce; wr_n = wr;
    repeat (4) @(negedge clk);
    ce_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
    fl_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_bus(logic fl, logic [3:0] a, logic [7:0] d);
    bus_cycle(1'b0, 1'b0, fl, a, d);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NDIG; i++) m_chr[i] = 8'h20;
    m_fl = '0; m_ctrl = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    push_all("R5", 1'b0);                      // R5 state held in reset
    rst_n = 1;
    repeat (2) @(negedge clk);

    bus_cycle(1'b1, 1'b0, 1'b1, 4'h8, 8'h77);  // R1 write low, ce high
    bus_cycle(1'b0, 1'b1, 1'b1, 4'h0, 8'h9F);  // R1 ce low, write high
    push_all("R1", 1'b0);

    for (int i = 0; i < NDIG; i++) begin       // R2 character writes
      logic [7:0] v;
      v = (i == 3) ? 8'hC5 : 8'h41 + 8'(i);
      wr_bus(1'b1, 4'h8 | 4'(i), v);
      m_chr[i] = v;
    end
    push_all("R2", 1'b0);

    wr_bus(1'b1, 4'h5, 8'h1A);                 // R3 A2..A0 ignored
    m_ctrl = 8'h1A;
    push_all("R3", 1'b0);

    wr_bus(1'b0, 4'hA, 8'hFE);                 // R4 D0=0, A3 ignored
    push_all("R4", 1'b0);
    wr_bus(1'b0, 4'hA, 8'h03); m_fl[2] = 1'b1;
    wr_bus(1'b0, 4'h7, 8'h01); m_fl[7] = 1'b1;
    push_all("R4", 1'b0);
    wr_bus(1'b0, 4'h2, 8'hFE); m_fl[2] = 1'b0;
    push_all("R4", 1'b0);

    @(negedge clk);                            // R9 data changed mid-strobe
    addr = 4'hE; data = 8'h30;
    @(negedge clk); ce_n = 0; wr_n = 0;
    repeat (6) @(negedge clk); data = 8'h31;
    repeat (6) @(negedge clk); ce_n = 1; wr_n = 1;
    repeat (3) @(negedge clk);
    m_chr[6] = 8'h30;
    push("R9", 0, 6, 8'h30);
    @(negedge clk);

    busy_cycles = 0;
    wr_bus(1'b1, 4'h0, 8'h85);                 // R6 start clear
    model_reset(); m_ctrl = 8'h85;
    push_all("R6", 1'b1);
    wr_bus(1'b1, 4'h9, 8'h55);                 // R7 char write in window
    wr_bus(1'b0, 4'h0, 8'h01);                 // R7 flash write in window
    push_all("R7", 1'b1);
    wait (!busy);
    repeat (3) @(negedge clk);
    checks++;
    if (busy_cycles != CLR) begin
      fails++;
      $display("FAIL R6 busy length actual=%0d expected=%0d", busy_cycles, CLR);
    end
    push_all("R6", 1'b0);

    wr_bus(1'b1, 4'h9, 8'h55); m_chr[1] = 8'h55; // R10 write after window
    push_all("R10", 1'b0);

    busy_cycles = 0;
    wr_bus(1'b1, 4'h0, 8'h80);                 // R8 early stop
    model_reset(); m_ctrl = 8'h80;
    wr_bus(1'b1, 4'h3, 8'h05); m_ctrl = 8'h05;
    push("R8", 3, 0, 8'h00);
    @(negedge clk);
    checks++;
    if (busy_cycles >= CLR || busy_cycles == 0) begin
      fails++;
      $display("FAIL R8 busy length actual=%0d expected=between 1 and %0d", busy_cycles, CLR - 1);
    end
    wr_bus(1'b1, 4'hA, 8'h66); m_chr[2] = 8'h66;
    push_all("R8", 1'b0);

    @(negedge clk); rst_n = 0;                 // R5 reset mid-run
    model_reset();
    repeat (2) @(negedge clk);
    push_all("R5", 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule